// File: doc/BRIEF.md
# PCI Window Address Translator

This block turns a 32-bit address seen on a PCI bus into a 34-bit DMA address. Four windows are programmed through register inputs. Each window has three 64-bit registers: a base, a mask and a translated base. An incoming address is compared against every window. The lowest-numbered window that is enabled and matches decides how the address is translated. If no window qualifies, the address is passed through unchanged.

A qualifying window works in one of two modes. In direct mode the window's translated base is spliced with the low bits of the bus address. In scatter-gather mode the block first builds the address of a page-table entry and issues one 64-bit read on its memory port. When the read data comes back, the DMA address is built from that data and the page offset of the bus address.

Requests are taken only while the block is idle. Each request produces exactly one result, flagged by a one-cycle valid pulse.

Top module: `pci_window_xlate`

## Requirements
- R1: After reset, `res_valid_o` and `mem_req_o` are low and `req_ready_o` is high.
- R2: Window n compares only bus-address bits 31:20, and only at the positions where its mask register holds 0. It matches when the bus address and its base register agree at every one of those positions.
- R3: When several windows qualify, the one with the lowest index wins.
- R4: A window whose base bit 0 is clear never qualifies, even if it matches. The search then moves on to the higher windows.
- R5: Direct mode is selected by base bit 1 = 0. Let keep = (mask & 0xFFF00000) | 0xFFFFF. The result is (tbase & ~keep) | (bus & keep). It appears with `res_valid_o` in the cycle after the request is accepted.
- R6: Scatter-gather mode is selected by base bit 1 = 1. One cycle after acceptance, `mem_req_o` pulses for one cycle. `mem_addr_o` then equals (tbase & ~(((mask & 0xFFF00000) >> 10) | 0x3FF)) | ((bus & ((mask & 0xFFF00000) | 0xFE000)) >> 10). It holds that value until the response arrives.
- R7: In scatter-gather mode, the result is ((pte & ~1) << 12) | (bus & 0x1FFF), where pte is the 64-bit response data. It appears with `res_valid_o` in the cycle after `mem_rsp_valid_i`.
- R8: Every translated result is the low 34 bits of the 64-bit computation.
- R9: When no window qualifies, the result is the bus address zero-extended to 34 bits. It appears in the cycle after acceptance.
- R10: While a fetch is outstanding, `req_ready_o` is low and new requests are ignored. A memory response that arrives while the block is idle has no effect.
- R11: Each request produces `res_valid_o` for exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid_i | input | 1 | Translation request |
| req_addr_i | input | 32 | Bus address to translate |
| req_ready_o | output | 1 | Block idle, request will be taken |
| res_valid_o | output | 1 | One-cycle result strobe |
| res_addr_o | output | 34 | Translated DMA address |
| win_base_i | input | 256 | Window base registers, window n at bits 64n+63:64n |
| win_mask_i | input | 256 | Window mask registers, same packing |
| win_tbase_i | input | 256 | Translated-base registers, same packing |
| mem_req_o | output | 1 | Page-table read strobe |
| mem_addr_o | output | 64 | Page-table entry address |
| mem_rsp_valid_i | input | 1 | Read data valid |
| mem_rsp_data_i | input | 64 | Page-table entry |

## Verification
A wrong window choice or a wrong mask field shows up as a wrong `res_addr_o` in the very next cycle for direct and pass-through addresses. For scatter-gather addresses it shows up one cycle after acceptance, as a wrong `mem_addr_o`. A state machine stuck in the wait state drops `req_ready_o` and withholds `res_valid_o`, so the next request stalls visibly. A state machine that leaves the wait state early produces a result strobe before the response, or one carrying stale page-table data. The sweep covers every value of bus bits 31:20 across overlapping, disabled and truncating windows, so each such fault surfaces within a few requests.

// File: rtl/pwx_pkg.sv
package pwx_pkg;
  localparam int unsigned REG_W    = 64;
  localparam int unsigned WIN_LSB  = 20;
  localparam int unsigned WIN_MSB  = 31;
  localparam int unsigned PTE_IDX_LSB = 13;
  localparam int unsigned TBL_SHIFT = 10;
  localparam int unsigned PG_SHIFT  = 12;
  localparam int unsigned OFS_BITS  = 13;

  localparam logic [REG_W-1:0] WIN_FIELD =
    ((REG_W'(1) << (WIN_MSB + 1)) - 1) ^ ((REG_W'(1) << WIN_LSB) - 1);
  localparam logic [REG_W-1:0] LOW_KEEP = (REG_W'(1) << WIN_LSB) - 1;
  localparam logic [REG_W-1:0] IDX_FIELD =
    ((REG_W'(1) << WIN_LSB) - 1) ^ ((REG_W'(1) << PTE_IDX_LSB) - 1);
  localparam logic [REG_W-1:0] TBL_LOW = (REG_W'(1) << TBL_SHIFT) - 1;
  localparam logic [REG_W-1:0] OFS_KEEP = (REG_W'(1) << OFS_BITS) - 1;

  typedef enum logic [0:0] {
    ST_IDLE = 1'b0,
    ST_WAIT = 1'b1
  } xl_state_t;
endpackage

// File: rtl/pwx_win_eval.sv
module pwx_win_eval
  import pwx_pkg::*;
#(
  parameter int unsigned AW = 32,
  parameter int unsigned DW = 34
) (
  input  logic [AW-1:0]    bus_i,
  input  logic [REG_W-1:0] base_i,
  input  logic [REG_W-1:0] mask_i,
  input  logic [REG_W-1:0] tbase_i,
  output logic             hit_o,
  output logic             sg_o,
  output logic [DW-1:0]    direct_o,
  output logic [REG_W-1:0] pte_addr_o
);
  logic [REG_W-1:0] bus_x, field, cmp, keep, tbl_mask;

  always_comb begin
    bus_x    = REG_W'(bus_i);
    field    = mask_i & WIN_FIELD;
    cmp      = ~mask_i & WIN_FIELD;
    hit_o    = base_i[0] && (((bus_x ^ base_i) & cmp) == '0);
    sg_o     = base_i[1];
    keep     = field | LOW_KEEP;
    direct_o = DW'((tbase_i & ~keep) | (bus_x & keep));
    tbl_mask = ~((field >> TBL_SHIFT) | TBL_LOW);
    pte_addr_o = (tbase_i & tbl_mask) |
                 ((bus_x & (field | IDX_FIELD)) >> TBL_SHIFT);
  end
endmodule

// File: rtl/pwx_prio_sel.sv
module pwx_prio_sel #(
  parameter int unsigned N = 4
) (
  input  logic [N-1:0] req_i,
  output logic [N-1:0] grant_o,
  output logic         any_o
);
  always_comb begin
    grant_o = '0;
    any_o   = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (req_i[i] && !any_o) begin
        grant_o[i] = 1'b1;
        any_o      = 1'b1;
      end
    end
  end
endmodule

// File: rtl/pci_window_xlate.sv
module pci_window_xlate
  import pwx_pkg::*;
#(
  parameter int unsigned NWIN = 4,
  parameter int unsigned AW   = 32,
  parameter int unsigned DW   = 34
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  req_valid_i,
  input  logic [AW-1:0]         req_addr_i,
  output logic                  req_ready_o,
  output logic                  res_valid_o,
  output logic [DW-1:0]         res_addr_o,
  input  logic [NWIN*REG_W-1:0] win_base_i,
  input  logic [NWIN*REG_W-1:0] win_mask_i,
  input  logic [NWIN*REG_W-1:0] win_tbase_i,
  output logic                  mem_req_o,
  output logic [REG_W-1:0]      mem_addr_o,
  input  logic                  mem_rsp_valid_i,
  input  logic [REG_W-1:0]      mem_rsp_data_i
);
  logic [NWIN-1:0]  hit, sg, grant;
  logic [DW-1:0]    dir_a [NWIN];
  logic [REG_W-1:0] pte_a [NWIN];
  logic             any_hit, sel_sg;
  logic [DW-1:0]    sel_dir;
  logic [REG_W-1:0] sel_pte;
  logic [AW-1:0]    bus_q;
  xl_state_t        st;
  logic             accept;

  for (genvar g = 0; g < NWIN; g++) begin : g_win
    pwx_win_eval #(.AW(AW), .DW(DW)) u_win (
      .bus_i      (req_addr_i),
      .base_i     (win_base_i[g*REG_W +: REG_W]),
      .mask_i     (win_mask_i[g*REG_W +: REG_W]),
      .tbase_i    (win_tbase_i[g*REG_W +: REG_W]),
      .hit_o      (hit[g]),
      .sg_o       (sg[g]),
      .direct_o   (dir_a[g]),
      .pte_addr_o (pte_a[g])
    );
  end

  pwx_prio_sel #(.N(NWIN)) u_sel (
    .req_i   (hit),
    .grant_o (grant),
    .any_o   (any_hit)
  );

  always_comb begin
    sel_sg  = 1'b0;
    sel_dir = '0;
    sel_pte = '0;
    for (int i = 0; i < NWIN; i++) begin
      if (grant[i]) begin
        sel_sg  = sg[i];
        sel_dir = dir_a[i];
        sel_pte = pte_a[i];
      end
    end
  end

  assign req_ready_o = (st == ST_IDLE);
  assign accept      = req_valid_i && (st == ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      st          <= ST_IDLE;
      res_valid_o <= 1'b0;
      res_addr_o  <= '0;
      mem_req_o   <= 1'b0;
      mem_addr_o  <= '0;
      bus_q       <= '0;
    end else begin
      res_valid_o <= 1'b0;
      mem_req_o   <= 1'b0;
      unique case (st)
        ST_IDLE: begin
          if (accept) begin
            bus_q <= req_addr_i;
            if (any_hit && sel_sg) begin
              mem_addr_o <= sel_pte;
              mem_req_o  <= 1'b1;
              st         <= ST_WAIT;
            end else begin
              res_valid_o <= 1'b1;
              res_addr_o  <= any_hit ? sel_dir : DW'(req_addr_i);
            end
          end
        end
        ST_WAIT: begin
          if (mem_rsp_valid_i) begin
            res_valid_o <= 1'b1;
            res_addr_o  <= DW'(((mem_rsp_data_i & ~REG_W'(1)) << PG_SHIFT) |
                               (REG_W'(bus_q) & OFS_KEEP));
            st          <= ST_IDLE;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  p_reset_state_r1: assert property (@(posedge clk)
    $past(rst) |-> (!res_valid_o && !mem_req_o && req_ready_o));

  p_one_grant_r3: assert property (@(posedge clk) disable iff (rst)
    $onehot0(grant));

  p_direct_lat_r5: assert property (@(posedge clk) disable iff (rst)
    (req_valid_i && req_ready_o && !(any_hit && sel_sg))
      |=> (res_valid_o && !mem_req_o && req_ready_o));

  p_sg_issue_r6: assert property (@(posedge clk) disable iff (rst)
    (req_valid_i && req_ready_o && any_hit && sel_sg)
      |=> (mem_req_o && !res_valid_o && !req_ready_o));

  p_addr_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (!req_ready_o && !mem_req_o) |-> $stable(mem_addr_o));

  p_rsp_done_r7: assert property (@(posedge clk) disable iff (rst)
    (!req_ready_o && mem_rsp_valid_i) |=> (res_valid_o && req_ready_o));

  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (rst)
    (req_ready_o && !req_valid_i) |=> (!res_valid_o && !mem_req_o));
endmodule

// File: tb/sim_pci_window_xlate.sv
module sim_pci_window_xlate;
  localparam int NW = 4;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             req_valid_i = 1'b0;
  logic [31:0]      req_addr_i = '0;
  logic             req_ready_o, res_valid_o, mem_req_o;
  logic [33:0]      res_addr_o;
  logic [NW*64-1:0] win_base_i, win_mask_i, win_tbase_i;
  logic [63:0]      mem_addr_o;
  logic             mem_rsp_valid_i = 1'b0;
  logic [63:0]      mem_rsp_data_i = '0;

  int tests = 0;
  int fails = 0;
  logic [63:0] cb [NW];
  logic [63:0] cm [NW];
  logic [63:0] ct [NW];

  always #2 clk = ~clk;

  pci_window_xlate u0 (
    .clk(clk), .rst(rst), .req_valid_i(req_valid_i), .req_addr_i(req_addr_i),
    .req_ready_o(req_ready_o), .res_valid_o(res_valid_o), .res_addr_o(res_addr_o),
    .win_base_i(win_base_i), .win_mask_i(win_mask_i), .win_tbase_i(win_tbase_i),
    .mem_req_o(mem_req_o), .mem_addr_o(mem_addr_o),
    .mem_rsp_valid_i(mem_rsp_valid_i), .mem_rsp_data_i(mem_rsp_data_i)
  );

  task automatic chk(input bit ok, input string rq, input logic [63:0] act,
                     input logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  function automatic logic [63:0] pte_of(input logic [63:0] a);
    return {a[31:0] ^ 32'h5A5A_1234, a[31:0]} | 64'h1;
  endfunction

  // kind: 0 pass-through, 1 direct, 2 scatter-gather
  task automatic model(input logic [31:0] bus, output int kind,
                       output logic [63:0] paddr, output logic [33:0] dma);
    logic [63:0] bx, fld, keep;
    kind = 0;
    paddr = '0;
    dma = {2'b00, bus};
    bx = {32'h0, bus};
    for (int i = 0; i < NW; i++) begin
      fld = cm[i] & 64'hFFF0_0000;
      if (kind == 0 && cb[i][0] &&
          ((bx & ~cm[i] & 64'hFFF0_0000) == (cb[i] & ~cm[i] & 64'hFFF0_0000))) begin
        if (cb[i][1]) begin
          kind = 2;
          paddr = (ct[i] & ~((fld >> 10) | 64'h3FF)) |
                  ((bx & (fld | 64'hFE000)) >> 10);
          dma = 34'(((pte_of(paddr) & ~64'h1) << 12) | (bx & 64'h1FFF));
        end else begin
          kind = 1;
          keep = fld | 64'hFFFFF;
          dma = 34'((ct[i] & ~keep) | (bx & keep));
        end
      end
    end
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    // W0 direct over 0x10x, W1 scatter-gather over 0x1xx (shadowed by W0),
    // W2 disabled over 0x200-0x3FF, W3 direct over 0x2xx with all-ones tbase.
    cb[0] = 64'h1000_0001; cm[0] = 64'h00F0_0000; ct[0] = 64'h0000_0002_ABC0_0000;
    cb[1] = 64'h1000_0003; cm[1] = 64'h0FF0_0000; ct[1] = 64'h0000_0001_2345_6000;
    cb[2] = 64'h2000_0000; cm[2] = 64'h1FF0_0000; ct[2] = 64'h0000_0000_1111_0000;
    cb[3] = 64'h2000_0001; cm[3] = 64'h0FF0_0000; ct[3] = 64'hFFFF_FFFF_FFFF_FFFF;
    for (int i = 0; i < NW; i++) begin
      win_base_i[i*64 +: 64]  = cb[i];
      win_mask_i[i*64 +: 64]  = cm[i];
      win_tbase_i[i*64 +: 64] = ct[i];
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    chk(!res_valid_o && !mem_req_o && req_ready_o, "R1 reset state",
        {61'h0, res_valid_o, mem_req_o, req_ready_o}, 64'h1);

    for (int hi = 0; hi < 4096; hi++) begin
      logic [31:0] bus;
      logic [63:0] pa;
      logic [33:0] exp;
      int kind;
      int lat;
      bus = {hi[11:0], 20'((hi * 32'h9E3B7) ^ 32'h1357)};
      model(bus, kind, pa, exp);
      lat = (hi % 3) + 1;

      if (hi % 5 == 0) begin
        mem_rsp_valid_i = 1'b1;
        mem_rsp_data_i = 64'hFFFF_0000_FFFF_0001;
        @(negedge clk);
        mem_rsp_valid_i = 1'b0;
        @(negedge clk);
        chk(!res_valid_o && req_ready_o, "R10 idle response ignored",
            {62'h0, res_valid_o, req_ready_o}, 64'h1);
      end

      req_valid_i = 1'b1;
      req_addr_i = bus;
      @(negedge clk);
      req_valid_i = 1'b0;

      if (kind == 2) begin
        chk(mem_req_o && !res_valid_o, "R6 fetch issued",
            {62'h0, mem_req_o, res_valid_o}, 64'h2);
        chk(mem_addr_o == pa, "R6 pte address", mem_addr_o, pa);
        for (int c = 0; c < lat; c++) begin
          if (hi % 2 == 1) begin
            req_valid_i = 1'b1;
            req_addr_i = ~bus;
          end
          @(negedge clk);
          req_valid_i = 1'b0;
          chk(!req_ready_o && !res_valid_o && !mem_req_o, "R10 busy while fetching",
              {61'h0, req_ready_o, res_valid_o, mem_req_o}, 64'h0);
          chk(mem_addr_o == pa, "R6 address held", mem_addr_o, pa);
        end
        mem_rsp_valid_i = 1'b1;
        mem_rsp_data_i = pte_of(pa);
        @(negedge clk);
        mem_rsp_valid_i = 1'b0;
        chk(res_valid_o, "R7 result after response", {63'h0, res_valid_o}, 64'h1);
        chk(res_addr_o == exp, "R7 R8 scatter-gather result",
            {30'h0, res_addr_o}, {30'h0, exp});
      end else begin
        chk(res_valid_o && !mem_req_o, kind == 1 ? "R5 direct strobe" : "R9 pass strobe",
            {62'h0, res_valid_o, mem_req_o}, 64'h2);
        chk(res_addr_o == exp,
            kind == 1 ? "R5 R2 R3 R4 R8 direct result" : "R9 R4 pass-through result",
            {30'h0, res_addr_o}, {30'h0, exp});
      end
      @(negedge clk);
      chk(!res_valid_o && req_ready_o, "R11 single-cycle strobe",
          {62'h0, res_valid_o, req_ready_o}, 64'h1);
    end
    finish_run();
  end
endmodule